// File: doc/BRIEF.md
# Pseudo-DMA Read Strobe Sequencer

This block turns a CPU access to a dedicated pseudo-DMA address window into one complete ISA-style DMA read handshake. A bridge decodes the window and raises a one-cycle select. If the peripheral is requesting service at that moment, the sequencer pulls the read strobe low. It then pulls the acknowledge strobe low and captures the byte the peripheral drives. It releases the acknowledge first and the read strobe after it. In the following cycle it samples the request line again to learn whether a block transfer is still running.

The CPU decides when each byte moves, so no address generation or transfer counting is involved. Every phase length is set by a parameter. The request input can be passed through a synchronizer of selectable depth. Three status flags report the state of the transfer: request present, byte ready, and block continues. An access made while no request is pending runs no handshake. It clears byte-ready and leaves the last captured byte on the data output.

Top module: `pdma_read_seq`

## Requirements
- R1: After reset both strobes are high (inactive), busy is low, byte-ready and block-continue are low, and the data output is zero.
- R2: A select that arrives while the synchronized request is low drives neither strobe, clears byte-ready and leaves the data output unchanged.
- R3: A select in idle with the request high pulls the read strobe low in the next cycle. The read strobe then stays low alone for SETUP_CYC cycles before the acknowledge strobe falls.
- R4: Both strobes stay low together for ACTIVE_CYC cycles. The byte on the peripheral data input during the last of those cycles becomes the data output.
- R5: The acknowledge strobe rises first. The read strobe stays low for HOLD_CYC more cycles and then rises.
- R6: The acknowledge strobe is never low while the read strobe is high.
- R7: In the cycle after both strobes are high again, the synchronized request is sampled. Block-continue takes that value and holds it until the next handshake.
- R8: Byte-ready goes high with each captured byte and goes low on a CPU byte read. If both happen in the same cycle, the capture wins.
- R9: A select made while a handshake is in progress has no effect. Both strobes stay high for at least one cycle between two handshakes.
- R10: The data-valid output is a single-cycle pulse in the cycle after the capture.
- R11: The request-present flag follows the request input after DRQ_SYNC clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_sel | input | 1 | One-cycle pulse: CPU access to the pseudo-DMA window |
| cpu_rd | input | 1 | One-cycle pulse: CPU read of the captured byte |
| cpu_data | output | DATA_W | Last captured byte |
| cpu_data_valid | output | 1 | Pulse marking a newly captured byte |
| busy | output | 1 | Handshake in progress |
| isa_drq | input | 1 | Peripheral DMA request, active high |
| isa_ior_n | output | 1 | Read strobe, active low |
| isa_dack_n | output | 1 | DMA acknowledge strobe, active low |
| isa_data | input | DATA_W | Peripheral data bus |
| stat_drq | output | 1 | Synchronized request present |
| stat_byte_rdy | output | 1 | Captured byte not yet read |
| stat_block | output | 1 | Request still high after the last handshake |

## Verification
The bench's peripheral model drives valid data only while both strobes are low. A sequencer that ordered the strobes wrongly, or captured the byte in the wrong cycle, would therefore deliver 0xFF instead of the expected byte. The bench checks the strobe levels on every cycle of each handshake. A design that released the strobes in the wrong order, or dropped the idle cycle between handshakes, is reported at that exact cycle. The bench also drops the request during the last byte of a block and checks that block-continue clears. A design that sampled the request before the strobes were released would keep the flag set. Finally, the bench sends a select with no request present and a second select during a handshake. A design that started a transfer on either one would produce an extra strobe pulse and an unexpected byte on the scoreboard.

// File: rtl/pdma_pkg.sv
package pdma_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_BOTH,
      ST_HOLD,
      ST_CHECK
   } pdma_state_e;

endpackage

// File: rtl/pdma_drq_sync.sv
module pdma_drq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_in,
   output logic req_out
);

   generate
      if (STAGES < 0) begin : g_bad_stages
         $error("pdma_drq_sync: STAGES must not be negative");
      end

      if (STAGES == 0) begin : g_direct
         assign req_out = req_in;
      end else begin : g_chain
         logic [STAGES-1:0] sync_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               sync_q <= '0;
            end else if (STAGES == 1) begin
               sync_q[0] <= req_in;
            end else begin
               sync_q <= {sync_q[STAGES-2:0], req_in};
            end
         end
         assign req_out = sync_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/pdma_phase_ctrl.sv
module pdma_phase_ctrl
   import pdma_pkg::*;
#(
   parameter int SETUP_CYC  = 1,
   parameter int ACTIVE_CYC = 1,
   parameter int HOLD_CYC   = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic drq,
   output logic ior_n,
   output logic dack_n,
   output logic capture,
   output logic check_now,
   output logic deny,
   output logic busy
);

   localparam int MAX_AB  = (SETUP_CYC > ACTIVE_CYC) ? SETUP_CYC : ACTIVE_CYC;
   localparam int MAX_LEN = (MAX_AB > HOLD_CYC) ? MAX_AB : HOLD_CYC;
   localparam int CNT_W   = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

   generate
      if (SETUP_CYC < 1 || ACTIVE_CYC < 1 || HOLD_CYC < 1) begin : g_bad_len
         $error("pdma_phase_ctrl: every phase must last at least one cycle");
      end
   endgenerate

   pdma_state_e       state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              phase_done;

   assign phase_done = (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start && drq) begin
                  state_q <= ST_SETUP;
                  cnt_q   <= CNT_W'(SETUP_CYC - 1);
               end
            end
            ST_SETUP: begin
               if (phase_done) begin
                  state_q <= ST_BOTH;
                  cnt_q   <= CNT_W'(ACTIVE_CYC - 1);
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            ST_BOTH: begin
               if (phase_done) begin
                  state_q <= ST_HOLD;
                  cnt_q   <= CNT_W'(HOLD_CYC - 1);
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            ST_HOLD: begin
               if (phase_done) begin
                  state_q <= ST_CHECK;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            ST_CHECK: state_q <= ST_IDLE;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      ior_n  = 1'b1;
      dack_n = 1'b1;
      case (state_q)
         ST_SETUP: ior_n = 1'b0;
         ST_BOTH: begin
            ior_n  = 1'b0;
            dack_n = 1'b0;
         end
         ST_HOLD: ior_n = 1'b0;
         default: ;
      endcase
   end

   assign capture   = (state_q == ST_BOTH) && phase_done;
   assign check_now = (state_q == ST_CHECK);
   assign deny      = (state_q == ST_IDLE) && start && !drq;
   assign busy      = (state_q != ST_IDLE);

   // R6: acknowledge only while the read strobe is active
   p_dack_needs_ior_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !dack_n |-> !ior_n);

   // R3: read strobe already low in the cycle before acknowledge falls
   p_ior_leads_dack_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dack_n) |-> $past(ior_n) == 1'b0);

   // R5: acknowledge released while read strobe still held
   p_dack_released_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dack_n) |-> !ior_n);

   // R9: after release the read strobe stays high at least one more cycle
   p_idle_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ior_n) |=> ior_n);

   // R2: no handshake without a request
   p_no_start_without_drq_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && start && !drq) |=> state_q == ST_IDLE);

endmodule

// File: rtl/pdma_capture.sv
module pdma_capture #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [DATA_W-1:0] bus_data,
   input  logic              check_now,
   input  logic              drq,
   input  logic              deny,
   input  logic              cpu_rd,
   output logic [DATA_W-1:0] data_q,
   output logic              valid_q,
   output logic              byte_rdy_q,
   output logic              block_q
);

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("pdma_capture: DATA_W must be positive");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_q     <= '0;
         valid_q    <= 1'b0;
         byte_rdy_q <= 1'b0;
         block_q    <= 1'b0;
      end else begin
         valid_q <= capture;
         if (capture) begin
            data_q     <= bus_data;
            byte_rdy_q <= 1'b1;
         end else if (cpu_rd || deny) begin
            byte_rdy_q <= 1'b0;
         end
         if (check_now) begin
            block_q <= drq;
         end
      end
   end

   // R10: the valid pulse lasts one cycle
   p_valid_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |=> !valid_q);

   // R8: a fresh byte is always flagged ready
   p_rdy_with_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |-> byte_rdy_q);

   // R7: block flag only moves on the post-release sample
   p_block_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !check_now |=> $stable(block_q));

endmodule

// File: rtl/pdma_read_seq.sv
module pdma_read_seq #(
   parameter int DATA_W     = 8,
   parameter int DRQ_SYNC   = 2,
   parameter int SETUP_CYC  = 1,
   parameter int ACTIVE_CYC = 1,
   parameter int HOLD_CYC   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_sel,
   input  logic              cpu_rd,
   output logic [DATA_W-1:0] cpu_data,
   output logic              cpu_data_valid,
   output logic              busy,
   input  logic              isa_drq,
   output logic              isa_ior_n,
   output logic              isa_dack_n,
   input  logic [DATA_W-1:0] isa_data,
   output logic              stat_drq,
   output logic              stat_byte_rdy,
   output logic              stat_block
);

   logic drq_s;
   logic capture;
   logic check_now;
   logic deny;

   pdma_drq_sync #(
      .STAGES (DRQ_SYNC)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_in  (isa_drq),
      .req_out (drq_s)
   );

   pdma_phase_ctrl #(
      .SETUP_CYC  (SETUP_CYC),
      .ACTIVE_CYC (ACTIVE_CYC),
      .HOLD_CYC   (HOLD_CYC)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (cpu_sel),
      .drq       (drq_s),
      .ior_n     (isa_ior_n),
      .dack_n    (isa_dack_n),
      .capture   (capture),
      .check_now (check_now),
      .deny      (deny),
      .busy      (busy)
   );

   pdma_capture #(
      .DATA_W (DATA_W)
   ) u_cap (
      .clk        (clk),
      .rst_n      (rst_n),
      .capture    (capture),
      .bus_data   (isa_data),
      .check_now  (check_now),
      .drq        (drq_s),
      .deny       (deny),
      .cpu_rd     (cpu_rd),
      .data_q     (cpu_data),
      .valid_q    (cpu_data_valid),
      .byte_rdy_q (stat_byte_rdy),
      .block_q    (stat_block)
   );

   assign stat_drq = drq_s;

endmodule

// File: tb/pdma_read_seq_tb_top.sv
module pdma_read_seq_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cpu_sel = 1'b0;
   logic       cpu_rd = 1'b0;
   logic [7:0] cpu_data;
   logic       cpu_data_valid;
   logic       busy;
   logic       isa_drq = 1'b0;
   logic       isa_ior_n;
   logic       isa_dack_n;
   logic [7:0] isa_data;
   logic       stat_drq;
   logic       stat_byte_rdy;
   logic       stat_block;
   logic [7:0] periph_byte = 8'h00;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;
   logic [7:0] exp_q[$];

   always #2.5 clk = ~clk;

   // peripheral drives its byte only while both strobes are active
   assign isa_data = (!isa_ior_n && !isa_dack_n) ? periph_byte : 8'hFF;

   pdma_read_seq dut_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .cpu_sel        (cpu_sel),
      .cpu_rd         (cpu_rd),
      .cpu_data       (cpu_data),
      .cpu_data_valid (cpu_data_valid),
      .busy           (busy),
      .isa_drq        (isa_drq),
      .isa_ior_n      (isa_ior_n),
      .isa_dack_n     (isa_dack_n),
      .isa_data       (isa_data),
      .stat_drq       (stat_drq),
      .stat_byte_rdy  (stat_byte_rdy),
      .stat_block     (stat_block)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic strobes(input string req, input logic ior, input logic dack);
      chk(isa_ior_n == ior,   req, "ior_n",  isa_ior_n,  ior);
      chk(isa_dack_n == dack, req, "dack_n", isa_dack_n, dack);
   endtask

   // monitor: pop expected bytes as the design delivers them (R4, R10)
   always @(negedge clk) begin
      if (rst_n && cpu_data_valid) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R4", "unexpected byte", cpu_data, 0);
         end else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk(cpu_data == e, "R4", "captured byte", cpu_data, e);
         end
      end
   end

   // one handshake; last=1 drops the request while the strobes are active
   task automatic do_xfer(input logic [7:0] b, input bit last, input bit extra_sel);
      @(negedge clk);
      cpu_sel = 1'b1;
      periph_byte = b;
      exp_q.push_back(b);
      @(negedge clk);
      cpu_sel = extra_sel;
      strobes("R3", 1'b0, 1'b1);
      @(negedge clk);
      cpu_sel = 1'b0;
      strobes("R4", 1'b0, 1'b0);
      if (last) isa_drq = 1'b0;
      @(negedge clk);
      strobes("R5", 1'b0, 1'b1);
      chk(cpu_data_valid == 1'b1, "R10", "valid pulse", cpu_data_valid, 1);
      @(negedge clk);
      strobes("R5", 1'b1, 1'b1);
      chk(cpu_data_valid == 1'b0, "R10", "valid low again", cpu_data_valid, 0);
      @(negedge clk);
      chk(busy == 1'b0, "R9", "idle after handshake", busy, 0);
      chk(stat_block == !last, "R7", "block continue", stat_block, !last);
      chk(stat_byte_rdy == 1'b1, "R8", "byte ready", stat_byte_rdy, 1);
   endtask

   task automatic cpu_read();
      @(negedge clk);
      cpu_rd = 1'b1;
      @(negedge clk);
      cpu_rd = 1'b0;
      chk(stat_byte_rdy == 1'b0, "R8", "ready cleared by read", stat_byte_rdy, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      strobes("R1", 1'b1, 1'b1);
      chk(busy == 1'b0, "R1", "busy", busy, 0);
      chk(stat_byte_rdy == 1'b0, "R1", "byte ready", stat_byte_rdy, 0);
      chk(stat_block == 1'b0, "R1", "block", stat_block, 0);
      chk(cpu_data == 8'h00, "R1", "data", cpu_data, 0);

      // R11 request synchronizer latency
      isa_drq = 1'b1;
      @(negedge clk);
      chk(stat_drq == 1'b0, "R11", "drq after one edge", stat_drq, 0);
      @(negedge clk);
      chk(stat_drq == 1'b1, "R11", "drq after two edges", stat_drq, 1);

      // block of three bytes, last one drops the request
      do_xfer(8'hA5, 1'b0, 1'b0);
      cpu_read();
      do_xfer(8'h3C, 1'b0, 1'b0);
      cpu_read();
      do_xfer(8'h5A, 1'b1, 1'b0);

      // R2 access with no request: no strobes, ready cleared, data held
      repeat (3) @(negedge clk);
      chk(stat_drq == 1'b0, "R2", "drq gone", stat_drq, 0);
      cpu_sel = 1'b1;
      @(negedge clk);
      cpu_sel = 1'b0;
      for (int i = 0; i < 4; i++) begin
         strobes("R2", 1'b1, 1'b1);
         @(negedge clk);
      end
      chk(stat_byte_rdy == 1'b0, "R2", "ready cleared", stat_byte_rdy, 0);
      chk(cpu_data == 8'h5A, "R2", "data held", cpu_data, 8'h5A);

      // R9 select held during a handshake starts nothing further
      isa_drq = 1'b1;
      repeat (3) @(negedge clk);
      do_xfer(8'hC3, 1'b0, 1'b1);
      for (int i = 0; i < 4; i++) begin
         strobes("R9", 1'b1, 1'b1);
         @(negedge clk);
      end

      // R8 read arriving with a fresh capture: capture wins
      @(negedge clk);
      cpu_sel = 1'b1;
      periph_byte = 8'h96;
      exp_q.push_back(8'h96);
      @(negedge clk);
      cpu_sel = 1'b0;
      cpu_rd = 1'b1;
      @(negedge clk);
      strobes("R4", 1'b0, 1'b0);
      @(negedge clk);
      cpu_rd = 1'b0;
      chk(stat_byte_rdy == 1'b1, "R8", "capture beats read", stat_byte_rdy, 1);
      repeat (3) @(negedge clk);
      chk(stat_block == 1'b1, "R7", "block still set", stat_block, 1);
      cpu_read();

      repeat (2) @(negedge clk);
      chk(exp_q.size() == 0, "R4", "bytes outstanding", exp_q.size(), 0);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule